// File: doc/BRIEF.md
# Nonvolatile Store Trigger Controller

This block decides when a battery-free nonvolatile SRAM copies its working contents into the nonvolatile array. It watches digitised supply flags (main supply under the switch level, backup capacitor under the switch level, and a strap that turns off the automatic power-down store). It also watches the sampled level of a shared open-drain store pin and a software store request. When a store is due, it pulls the shared pin low for a fixed 20 ms window. During that window it checks whether the pin really went low. It then either issues a store-in-progress strobe to the array or gives up and flags an abort.

An external agent can veto an automatic store by holding the pin high against the pull-down. An external agent can request a store by driving the pin low while the block is idle. Whenever the capacitor is under threshold, SRAM writes are gated off and externally requested stores are ignored. Writes are also gated off for the whole of a store attempt.

Top module: `nvstore_ctrl`

## Requirements
- R1: When `auto_inhibit_i` is 0, a rising edge of `vmain_low_i` in the idle state starts a store attempt, and `pin_pulldown_o` goes high on the next clock.
- R2: Once a store attempt starts, `pin_pulldown_o` stays high for exactly PULL_MS × CLK_PER_MS consecutive clock cycles.
- R3: If the synchronised pin level never reads 0 during the pull-down window, the attempt ends with `abort_o` and `store_strobe_o` never rises. Otherwise `store_strobe_o` rises.
- R4: `abort_o` is a single-cycle pulse, and the block is idle in the following cycle.
- R5: While `vcap_low_i` is 1, a software request or a falling edge on the store pin does not start a store.
- R6: While `vcap_low_i` is 1, `sram_we_en_o` is 0 from the next clock onward.
- R7: While `auto_inhibit_i` is 1, a supply drop never starts a store. Software and pin requests still do.
- R8: A 1-to-0 transition of `pin_level_i`, seen through a two-flop synchroniser while the block is idle, starts a store attempt.
- R9: `store_strobe_o` stays high until `array_done_i` is 1, and the block is idle one cycle later. `sram_we_en_o` is 0 whenever `pin_pulldown_o` or `store_strobe_o` is high.
- R10: Requests that arrive while an attempt is in progress are dropped, not queued.
- R11: Synchronous active-high reset releases the pin, clears the strobe and the abort flag, and sets `sram_we_en_o` to the inverse of `vcap_low_i`.
- R12: The capacitor flag does not block an automatic store that a supply drop starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vmain_low_i | input | 1 | Main supply below switch level |
| vcap_low_i | input | 1 | Backup capacitor below switch level |
| auto_inhibit_i | input | 1 | 1 disables the power-down automatic store |
| pin_level_i | input | 1 | Sampled level of the shared store pin (asynchronous) |
| sw_store_req_i | input | 1 | Software store request, one-cycle pulse |
| array_done_i | input | 1 | Array reports that the store has completed |
| pin_pulldown_o | output | 1 | Open-drain pull-down enable for the store pin |
| store_strobe_o | output | 1 | Store in progress, to the array |
| sram_we_en_o | output | 1 | SRAM write-enable gate |
| abort_o | output | 1 | One-cycle pulse when an attempt is abandoned |

## Verification
The bench holds the pin high against the pull-down for both automatic and software attempts. A controller that skipped the level check would store anyway, where the correct result is an abort pulse. It measures the pull-down window length exactly, so an off-by-one timer shows up as a run of 99 or 101 cycles. It raises the capacitor flag alongside software and pin requests, which a missing gate would wrongly honour. It raises the same flag under a supply drop, which an over-eager gate would wrongly block. Finally, it fires every kind of request in the middle of a store and then watches for a second pull-down after done, which a controller that latched requests would produce.

// File: rtl/nvstore_pkg.sv
package nvstore_pkg;

  // One-hot controller states
  typedef enum logic [4:0] {
    ST_IDLE  = 5'b00001,
    ST_PULL  = 5'b00010,
    ST_CHECK = 5'b00100,
    ST_STORE = 5'b01000,
    ST_ABORT = 5'b10000
  } nv_state_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/nvstore_pin_sync.sv
module nvstore_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  // Pin idles high through its pull-up, so reset to 1
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/nvstore_hold_timer.sv
module nvstore_hold_timer #(
  parameter int unsigned CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // Counter sits at zero whenever the window is not running
  always_ff @(posedge clk) begin
    if (rst || !run_i)
      cnt_q <= '0;
    else if (!done_o)
      cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/nvstore_req_arb.sv
module nvstore_req_arb (
  input  logic clk,
  input  logic rst,
  input  logic idle_i,
  input  logic vmain_low_i,
  input  logic vcap_low_i,
  input  logic auto_inhibit_i,
  input  logic sw_req_i,
  input  logic hw_fall_i,
  output logic start_o
);

  logic vmain_q;
  logic auto_go;
  logic ext_go;

  always_ff @(posedge clk) begin
    if (rst) vmain_q <= 1'b0;
    else     vmain_q <= vmain_low_i;
  end

  // A supply drop is an internal trigger: only the strap masks it.
  // Software and pin requests are external: the capacitor flag masks them.
  assign auto_go = vmain_low_i & ~vmain_q & ~auto_inhibit_i;
  assign ext_go  = (sw_req_i | hw_fall_i) & ~vcap_low_i;
  assign start_o = idle_i & (auto_go | ext_go);

endmodule

// File: rtl/nvstore_ctrl.sv
module nvstore_ctrl #(
  parameter int unsigned CLK_PER_MS = 50000,
  parameter int unsigned PULL_MS    = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic vmain_low_i,
  input  logic vcap_low_i,
  input  logic auto_inhibit_i,
  input  logic pin_level_i,
  input  logic sw_store_req_i,
  input  logic array_done_i,
  output logic pin_pulldown_o,
  output logic store_strobe_o,
  output logic sram_we_en_o,
  output logic abort_o
);
  import nvstore_pkg::*;

  localparam int unsigned PULL_CYCLES = CLK_PER_MS * PULL_MS;

  nv_state_e st_q, st_nx;
  logic      pin_lvl_s, pin_fall_s;
  logic      start, win_done, seen_low_q, we_q;

  nvstore_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_level_i),
    .level_o(pin_lvl_s),
    .fall_o (pin_fall_s)
  );

  nvstore_req_arb u_arb (
    .clk           (clk),
    .rst           (rst),
    .idle_i        (st_q == ST_IDLE),
    .vmain_low_i   (vmain_low_i),
    .vcap_low_i    (vcap_low_i),
    .auto_inhibit_i(auto_inhibit_i),
    .sw_req_i      (sw_store_req_i),
    .hw_fall_i     (pin_fall_s),
    .start_o       (start)
  );

  nvstore_hold_timer #(.CYCLES(PULL_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run_i (st_q == ST_PULL),
    .done_o(win_done)
  );

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      ST_IDLE:  if (start)        st_nx = ST_PULL;
      ST_PULL:  if (win_done)     st_nx = ST_CHECK;
      ST_CHECK: st_nx = seen_low_q ? ST_STORE : ST_ABORT;
      ST_STORE: if (array_done_i) st_nx = ST_IDLE;
      ST_ABORT: st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      seen_low_q <= 1'b0;
      we_q       <= ~vcap_low_i;
    end else begin
      st_q <= st_nx;
      if (st_q == ST_PULL) begin
        if (!pin_lvl_s) seen_low_q <= 1'b1;
      end else if (st_q == ST_IDLE) begin
        seen_low_q <= 1'b0;
      end
      we_q <= ~vcap_low_i & ((st_nx == ST_IDLE) | (st_nx == ST_ABORT));
    end
  end

  assign pin_pulldown_o = st_q[1];
  assign store_strobe_o = st_q[3];
  assign abort_o        = st_q[4];
  assign sram_we_en_o   = we_q;

endmodule

// File: rtl/nvstore_ctrl_chk.sv
module nvstore_ctrl_chk #(
  parameter int unsigned PULL_CYCLES = 20
) (
  input logic clk,
  input logic rst,
  input logic vcap_low_i,
  input logic array_done_i,
  input logic pin_pulldown_o,
  input logic store_strobe_o,
  input logic sram_we_en_o,
  input logic abort_o
);

  int unsigned run_q;

  always_ff @(posedge clk) begin
    if (rst)                 run_q <= 0;
    else if (pin_pulldown_o) run_q <= run_q + 1;
    else                     run_q <= 0;
  end

  assert_pull_window_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_pulldown_o) |-> run_q == PULL_CYCLES);

  assert_abort_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o && !pin_pulldown_o && !store_strobe_o);

  assert_cap_gate_R6: assert property (@(posedge clk) disable iff (rst)
    vcap_low_i |=> !sram_we_en_o);

  assert_busy_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (pin_pulldown_o || store_strobe_o) |-> !sram_we_en_o);

  assert_strobe_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (store_strobe_o && !array_done_i) |=> store_strobe_o);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (store_strobe_o && array_done_i) |=> !store_strobe_o && !pin_pulldown_o);

endmodule

bind nvstore_ctrl nvstore_ctrl_chk #(.PULL_CYCLES(PULL_CYCLES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .vcap_low_i    (vcap_low_i),
  .array_done_i  (array_done_i),
  .pin_pulldown_o(pin_pulldown_o),
  .store_strobe_o(store_strobe_o),
  .sram_we_en_o  (sram_we_en_o),
  .abort_o       (abort_o)
);

// File: tb/tb_nvstore_ctrl.sv
module tb_nvstore_ctrl;

  localparam int unsigned CPM  = 5;
  localparam int unsigned PMS  = 20;
  localparam int unsigned PULL = CPM * PMS;
  localparam int          NVEC = 11;

  // vector: [7:6] kind (0 supply drop, 1 software, 2 pin low)
  //         [5] strap, [4] cap low, [3] hold pin high, [1:0] outcome (0 none, 1 store, 2 abort)
  localparam logic [7:0] VEC [NVEC] = '{
    8'b00_000_0_01, // R1 auto store
    8'b00_001_0_10, // R3 auto vetoed
    8'b00_100_0_00, // R7 strap blocks auto
    8'b01_000_0_01, // software store
    8'b01_010_0_00, // R5 software blocked by cap
    8'b10_000_0_01, // R8 pin request
    8'b10_010_0_00, // R5 pin blocked by cap
    8'b01_100_0_01, // R7 software under strap
    8'b10_100_0_01, // R7 pin under strap
    8'b01_001_0_10, // R3 software vetoed
    8'b00_010_0_01  // R12 auto with cap low
  };

  logic clk = 0, rst = 1;
  logic vmain = 0, vcap = 0, inh = 0, sw = 0, done = 0;
  logic ext_low = 0, hold_hi = 0;
  logic pd, strobe, we, abrt, pin;
  int   checks = 0, errors = 0;
  bit   finished = 0;

  always #2 clk = ~clk;

  assign pin = ~((pd & ~hold_hi) | ext_low);

  nvstore_ctrl #(.CLK_PER_MS(CPM), .PULL_MS(PMS)) dut (
    .clk(clk), .rst(rst), .vmain_low_i(vmain), .vcap_low_i(vcap),
    .auto_inhibit_i(inh), .pin_level_i(pin), .sw_store_req_i(sw),
    .array_done_i(done), .pin_pulldown_o(pd), .store_strobe_o(strobe),
    .sram_we_en_o(we), .abort_o(abrt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_vec(input int idx);
    logic [1:0] kind, exp;
    int pd_cnt, st_cnt, ab_cnt, outcome;
    bit we_bad;
    kind = VEC[idx][7:6];
    exp  = VEC[idx][1:0];
    inh = VEC[idx][5]; vcap = VEC[idx][4]; hold_hi = VEC[idx][3];
    cyc(3);
    pd_cnt = 0; st_cnt = 0; ab_cnt = 0; we_bad = 0;
    for (int i = 0; i < 2 * PULL + 40; i++) begin
      vmain   = (kind == 2'd0);
      sw      = (kind == 2'd1) && (i == 0);
      ext_low = (kind == 2'd2) && (i < 4);
      done    = strobe && (st_cnt == 3);
      @(negedge clk);
      if (pd) pd_cnt++;
      if (strobe) st_cnt++;
      if (abrt) ab_cnt++;
      if ((pd || strobe) && we) we_bad = 1;
    end
    done = 0; sw = 0; ext_low = 0;
    outcome = (ab_cnt > 0) ? 2 : (st_cnt > 0) ? 1 : 0;
    check(outcome == exp, $sformatf("vector %0d outcome R1 R3 R5 R7 R8 R12", idx), outcome, exp);
    if (pd_cnt > 0) check(pd_cnt == PULL, $sformatf("vector %0d R2 window", idx), pd_cnt, PULL);
    if (ab_cnt > 0) check(ab_cnt == 1, $sformatf("vector %0d R4 pulse", idx), ab_cnt, 1);
    check(!we_bad, $sformatf("vector %0d R9 write gate", idx), we_bad, 0);
    vmain = 0; inh = 0; vcap = 0; hold_hi = 0;
    cyc(5);
  endtask

  initial begin
    int pd_seen;
    // R11 reset state with capacitor healthy
    rst = 1; cyc(3);
    check(!pd && !strobe && !abrt, "R11 outputs idle", {pd, strobe, abrt}, 0);
    check(we == 1, "R11 write enable", we, 1);
    vcap = 1; cyc(2);
    check(we == 0, "R11 write enable with cap low", we, 0);
    vcap = 0; cyc(1); rst = 0; cyc(3);

    for (int v = 0; v < NVEC; v++) run_vec(v);

    // R6 cap flag gates writes while idle
    vcap = 1; cyc(1);
    check(we == 0, "R6 we drops with cap low", we, 0);
    vcap = 0; cyc(1);
    check(we == 1, "R6 we restores", we, 1);

    // R10 requests during a store are dropped
    sw = 1; cyc(1); sw = 0;
    cyc(PULL + 3);
    check(strobe == 1, "R10 store underway", strobe, 1);
    check(we == 0, "R9 we low while storing", we, 0);
    sw = 1; vmain = 1; ext_low = 1; cyc(1); sw = 0; cyc(3); ext_low = 0; cyc(3);
    check(strobe == 1, "R9 strobe held until done", strobe, 1);
    done = 1; cyc(1); done = 0;
    check(strobe == 0, "R9 strobe drops after done", strobe, 0);
    pd_seen = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (pd) pd_seen++;
    end
    check(pd_seen == 0, "R10 no queued request", pd_seen, 0);
    check(we == 1, "R9 we back after store", we, 1);
    vmain = 0; cyc(2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule